// File: doc/BRIEF.md
# Retriggerable Buffered PWM Timer

This block is a 16-bit up-counter that drives three pulse-width outputs and a toggle output. After software sets the enable bit, the counter sits idle at all-ones until a trigger arrives. A trigger is a write of 1 to the software-trigger address, or a selected edge on the external trigger pin. Every trigger clears the count to zero and starts a new period. A trigger that arrives in the middle of a period restarts it at once. The counter advances on a count-enable strobe from a power-of-two prescaler.

Software writes a period value and three duty values into compare registers. The counter compares against working buffers, not against those registers. The buffers take new register values only when the count reaches the period value and wraps to zero, so a write in mid-period never produces a short or torn pulse. While the block is disabled, the buffers follow the registers on every cycle. The next enable therefore starts from the values last written.

Top module: `rtpwm_timer`

## Requirements
- R1: After reset, and after enabling without a trigger, all outputs stay low and the counter does not advance.
- R2: A write to address 1 with data bit 0 set is a software trigger. It takes effect two clock edges after the write is presented.
- R3: Control bits [5:4] select the external edge: 00 none, 01 rising, 10 falling, 11 both. The pin passes through two synchronizing flops, and a qualifying edge presented before clock edge c takes effect at edge c+2. Edges that are not selected are ignored.
- R4: A trigger clears the count to zero. The count advances on each following count strobe. A trigger during a running period restarts the period.
- R5: The period is (CMP0+1) count strobes. `irq_period` pulses for one cycle when the count wraps from CMP0 to zero.
- R6: Output `pwm_out[b]` is high while the count is below CMP(b+1), which gives CMP(b+1) strobes per period. `irq_match[b]` pulses for one cycle when the count reaches CMP(b+1).
- R7: The compare registers live at addresses 4 to 7 (CMP0 to CMP3). A write to them while running has effect only from the next wrap.
- R8: Every trigger drives all `pwm_out` bits high, whatever their prior level, and inverts `toggle_out`.
- R9: Control bits [3:1] hold the value k, and the count strobe then occurs once every 2^k clocks (k = 0 to 7).
- R10: Control bit 0 is the enable. Two edges after a write that clears it, all outputs are low. While disabled, the buffers copy the registers, so the next period after re-enabling uses the latest values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 software trigger, 4..7 compare) |
| wr_data | input | 16 | Register write data |
| ext_trig_in | input | 1 | Asynchronous external trigger pin |
| toggle_out | output | 1 | Inverts on every trigger |
| pwm_out | output | 3 | Pulse-width outputs, one per duty channel |
| irq_period | output | 1 | One-cycle pulse at period wrap |
| irq_match | output | 3 | One-cycle pulse per channel on compare match |

## Verification
Several rules are checked on every cycle by assertions:
- The idle state is quiet, holds the count at all-ones and keeps the outputs low.
- A trigger zeroes the count, raises the PWM outputs and flips the toggle.
- The count never passes the period buffer.
- The buffers hold still except at a wrap.
- With divide-by-two selected, strobes never fall on two consecutive cycles.

Other behaviour can only be shown by the bench scenarios:
- A mid-period compare write takes effect one period late.
- A retrigger moves the period interrupt.
- Each edge-select setting reacts to exactly the edges it names.
- Values written while disabled shape the first period after re-enabling.
- The prescaler stretches both the period and the pulse width.

// File: rtl/rtpwm_pkg.sv
package rtpwm_pkg;
  localparam int unsigned CTRL_ADDR   = 0;
  localparam int unsigned SWTRIG_ADDR = 1;
  localparam int unsigned CMP_BASE    = 4;

  // bit 0 enable, bits 3:1 divider exponent, bits 5:4 edge select
  typedef struct packed {
    logic [1:0] edge_sel;  // [0] rising, [1] falling
    logic [2:0] div_exp;
    logic       enable;
  } ctrl_t;
endpackage

// File: rtl/rtpwm_regs.sv
module rtpwm_regs
  import rtpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 3,
  parameter int ADDR_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [CNT_W-1:0]            wr_data,
  output ctrl_t                       ctrl,
  output logic [NCH:0][CNT_W-1:0]     cmp,
  output logic                        sw_trig
);
  localparam int CTRL_W = $bits(ctrl_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      cmp     <= '0;
      sw_trig <= 1'b0;
    end else begin
      sw_trig <= wr_en && (wr_addr == ADDR_W'(SWTRIG_ADDR)) && wr_data[0];
      if (wr_en) begin
        if (wr_addr == ADDR_W'(CTRL_ADDR))
          ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        for (int k = 0; k <= NCH; k++)
          if (wr_addr == ADDR_W'(CMP_BASE + k))
            cmp[k] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rtpwm_prescale.sv
module rtpwm_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PS_W = (2 ** SEL_W) - 1;

  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] mask;

  always_comb begin
    mask = (PS_W'(1) << sel) - PS_W'(1);
    tick = en && ((pcnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) pcnt <= '0;
    else            pcnt <= pcnt + PS_W'(1);
  end

  // R9: with divide-by-two selected, strobes never come back to back
  p_div2_gap_r9: assert property (@(posedge clk) disable iff (rst)
    (en && sel == SEL_W'(1) && tick) |=> (!tick || !en || sel != SEL_W'(1)));
endmodule

// File: rtl/rtpwm_trig.sv
module rtpwm_trig (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] edge_sel,
  input  logic       pin,
  output logic       pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) {s1, s2, s3} <= 3'b000;
    else     {s1, s2, s3} <= {pin, s1, s2};
  end

  always_comb
    pulse = en && ((edge_sel[0] && s2 && !s3) || (edge_sel[1] && !s2 && s3));
endmodule

// File: rtl/rtpwm_core.sv
module rtpwm_core #(
  parameter int CNT_W = 16,
  parameter int NCH   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    tick,
  input  logic                    trig,
  input  logic [NCH:0][CNT_W-1:0] cmp,
  output logic [NCH-1:0]          pwm,
  output logic                    tog,
  output logic                    irq_period,
  output logic [NCH-1:0]          irq_cmp
);
  logic [CNT_W-1:0]          cnt, cnt_nx;
  logic                      running, wrap;
  logic [NCH:0][CNT_W-1:0]   bufs, bufs_nx;
  logic [NCH-1:0]            lt_nx, eq_nx;

  always_comb begin
    wrap    = running && tick && (cnt == bufs[0]);
    cnt_nx  = wrap ? '0 : cnt + CNT_W'(1);
    bufs_nx = wrap ? cmp : bufs;
  end

  for (genvar b = 0; b < NCH; b++) begin : g_ch
    assign lt_nx[b] = cnt_nx <  bufs_nx[b+1];
    assign eq_nx[b] = cnt_nx == bufs_nx[b+1];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt        <= '1;
      running    <= 1'b0;
      pwm        <= '0;
      tog        <= 1'b0;
      irq_period <= 1'b0;
      irq_cmp    <= '0;
      bufs       <= rst ? '0 : cmp;
    end else begin
      irq_period <= 1'b0;
      irq_cmp    <= '0;
      if (trig) begin
        cnt     <= '0;
        running <= 1'b1;
        pwm     <= '1;
        tog     <= ~tog;
      end else if (running && tick) begin
        cnt        <= cnt_nx;
        bufs       <= bufs_nx;
        irq_period <= wrap;
        pwm        <= lt_nx;
        irq_cmp    <= eq_nx;
      end
    end
  end

  // R1: idle means quiet outputs and a held all-ones count
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !running |-> (cnt == '1 && pwm == '0 && irq_cmp == '0 && !irq_period));
  // R4: a trigger zeroes the counter
  p_trig_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (en && trig) |=> (cnt == '0 && running));
  // R8: a trigger raises every output and flips the toggle
  p_trig_force_r8: assert property (@(posedge clk) disable iff (rst)
    (en && trig) |=> (pwm == '1 && tog != $past(tog)));
  // R5: the count never exceeds the period buffer
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    running |-> cnt <= bufs[0]);
  // R5: the period wrap clears the count and raises the period interrupt
  p_wrap_irq_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !trig && running && tick && cnt == bufs[0]) |=> (cnt == '0 && irq_period));
  // R7: buffers move only at a wrap while enabled
  p_buf_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !(running && tick && cnt == bufs[0])) |=> $stable(bufs));
  // R10: disabled means everything low
  p_off_low_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pwm == '0 && !tog && !irq_period && irq_cmp == '0));
endmodule

// File: rtl/rtpwm_timer.sv
module rtpwm_timer
  import rtpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 3,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              ext_trig_in,
  output logic              toggle_out,
  output logic [NCH-1:0]    pwm_out,
  output logic              irq_period,
  output logic [NCH-1:0]    irq_match
);
  ctrl_t                   ctrl;
  logic [NCH:0][CNT_W-1:0] cmp;
  logic                    sw_trig, ext_pulse, tick, trig;

  rtpwm_regs #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .cmp(cmp), .sw_trig(sw_trig)
  );

  rtpwm_prescale #(.SEL_W(SEL_W)) u_ps (
    .clk(clk), .rst(rst), .en(ctrl.enable), .sel(SEL_W'(ctrl.div_exp)), .tick(tick)
  );

  rtpwm_trig u_trig (
    .clk(clk), .rst(rst), .en(ctrl.enable), .edge_sel(ctrl.edge_sel),
    .pin(ext_trig_in), .pulse(ext_pulse)
  );

  assign trig = ctrl.enable && (sw_trig || ext_pulse);

  rtpwm_core #(.CNT_W(CNT_W), .NCH(NCH)) u_core (
    .clk(clk), .rst(rst), .en(ctrl.enable), .tick(tick), .trig(trig), .cmp(cmp),
    .pwm(pwm_out), .tog(toggle_out), .irq_period(irq_period), .irq_cmp(irq_match)
  );
endmodule

// File: tb/test_rtpwm_timer.sv
`timescale 1ns/1ps
module test_rtpwm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ext_trig_in = 1'b0;
  logic        toggle_out, irq_period;
  logic [2:0]  pwm_out, irq_match;

  rtpwm_timer i_rtpwm_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_trig_in(ext_trig_in), .toggle_out(toggle_out), .pwm_out(pwm_out),
    .irq_period(irq_period), .irq_match(irq_match)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {int cyc; int sig; int val; string req;} exp_t;
  exp_t q[$];

  // signal codes: 0 toggle, 1..3 pwm, 4 period irq, 5..7 match irq
  function automatic int sigval(int s);
    case (s)
      0: return int'(toggle_out);
      1, 2, 3: return int'(pwm_out[s-1]);
      4: return int'(irq_period);
      default: return int'(irq_match[s-5]);
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic expect_at(int c, int s, int v, string r);
    q.push_back('{c, s, v, r});
  endtask

  // monitor: pops every expected item due this cycle
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          check($sformatf("%s sig%0d", q[i].req, q[i].sig), sigval(q[i].sig), q[i].val);
          q.delete(i);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d, output int c);
    @(negedge clk);
    c = cyc;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic goto(int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic ext_drive(logic v, output int c);
    @(negedge clk);
    ext_trig_in = v;
    c = cyc;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 0);
    $finish;
  end

  initial begin
    int c, t, t2, t3, t4, p1, p2, hi;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 reset pwm", int'(pwm_out), 0);
    check("R1 reset toggle", int'(toggle_out), 0);
    check("R1 reset irq", int'({irq_period, irq_match}), 0);

    wr(3'd4, 16'd9, c); wr(3'd5, 16'd3, c); wr(3'd6, 16'd5, c); wr(3'd7, 16'd9, c);
    wr(3'd0, 16'h0001, c);
    repeat (20) @(negedge clk);
    // R1: enabled but waiting
    check("R1 wait pwm", int'(pwm_out), 0);
    check("R1 wait irq", int'({irq_period, irq_match}), 0);

    // R2 software trigger, first period
    wr(3'd1, 16'h0001, c);
    t = c + 2;
    expect_at(t - 1, 0, 0, "R2");
    expect_at(t, 0, 1, "R8 toggle");
    for (int b = 1; b <= 3; b++) expect_at(t, b, 1, "R8 pwm high");
    expect_at(t + 2, 1, 1, "R6");
    expect_at(t + 3, 1, 0, "R6");
    expect_at(t + 3, 5, 1, "R6 irq1");
    expect_at(t + 4, 5, 0, "R6 irq1 pulse");
    expect_at(t + 5, 2, 0, "R6");
    expect_at(t + 5, 6, 1, "R6 irq2");
    expect_at(t + 8, 3, 1, "R6");
    expect_at(t + 9, 3, 0, "R6");
    expect_at(t + 9, 7, 1, "R6 irq3");
    expect_at(t + 9, 4, 0, "R5");
    expect_at(t + 10, 4, 1, "R5 wrap");
    expect_at(t + 11, 4, 0, "R5 pulse");
    expect_at(t + 10, 1, 1, "R6 new period");
    expect_at(t + 20, 4, 1, "R5 second wrap");
    // R7: CMP1 := 6 written at count 2 of period 2; old value still used
    expect_at(t + 13, 1, 0, "R7 old duty");
    expect_at(t + 25, 1, 1, "R7 new duty");
    expect_at(t + 26, 1, 0, "R7 new duty");
    expect_at(t + 26, 5, 1, "R7 irq1");
    goto(t + 10);
    wr(3'd5, 16'd6, c);

    // R4: retrigger at count 8 of the period starting at t+30
    expect_at(t + 37, 1, 0, "R4 before");
    goto(t + 35);
    wr(3'd1, 16'h0001, c);
    t2 = c + 2;
    for (int b = 1; b <= 3; b++) expect_at(t2, b, 1, "R8 forced");
    expect_at(t2, 0, 0, "R8 toggle");
    expect_at(t + 40, 4, 0, "R4 old wrap gone");
    expect_at(t2 + 10, 4, 1, "R4 restarted wrap");
    expect_at(t2 + 6, 1, 0, "R4 duty after restart");
    goto(t2 + 12);

    // R3 external edges (toggle now 0)
    wr(3'd0, 16'h0011, c);
    ext_drive(1'b1, c);
    expect_at(c + 2, 0, 0, "R3 sync delay");
    expect_at(c + 3, 0, 1, "R3 rising");
    repeat (8) @(negedge clk);
    ext_drive(1'b0, c);
    expect_at(c + 3, 0, 1, "R3 fall ignored");
    expect_at(c + 4, 0, 1, "R3 fall ignored");
    repeat (8) @(negedge clk);
    wr(3'd0, 16'h0031, c);
    ext_drive(1'b1, c);
    expect_at(c + 3, 0, 0, "R3 both rise");
    repeat (8) @(negedge clk);
    ext_drive(1'b0, c);
    expect_at(c + 3, 0, 1, "R3 both fall");
    repeat (8) @(negedge clk);
    wr(3'd0, 16'h0021, c);
    ext_drive(1'b1, c);
    expect_at(c + 4, 0, 1, "R3 rise ignored");
    repeat (8) @(negedge clk);
    ext_drive(1'b0, c);
    expect_at(c + 3, 0, 0, "R3 falling");
    repeat (8) @(negedge clk);
    wr(3'd0, 16'h0001, c);
    ext_drive(1'b1, c);
    expect_at(c + 4, 0, 0, "R3 off ignored");
    expect_at(c + 6, 0, 0, "R3 off ignored");
    repeat (8) @(negedge clk);
    ext_trig_in = 1'b0;
    repeat (4) @(negedge clk);

    // R10: trigger then disable
    wr(3'd1, 16'h0001, c);
    t3 = c + 2;
    expect_at(t3, 0, 1, "R8");
    expect_at(t3 + 1, 3, 1, "R10 still on");
    wr(3'd0, 16'h0000, c);
    for (int b = 0; b <= 3; b++) expect_at(t3 + 2, b, 0, "R10 off");
    repeat (6) @(negedge clk);

    // R10: values written while disabled are used after enable
    wr(3'd4, 16'd4, c); wr(3'd5, 16'd2, c);
    wr(3'd0, 16'h0001, c);
    wr(3'd1, 16'h0001, c);
    t4 = c + 2;
    expect_at(t4 + 1, 1, 1, "R10 duty");
    expect_at(t4 + 2, 1, 0, "R10 duty");
    expect_at(t4 + 5, 4, 1, "R10 period");
    expect_at(t4 + 5, 2, 1, "R6 cmp above period");
    expect_at(t4 + 10, 4, 1, "R10 period");
    goto(t4 + 12);

    // R9 prescaler: divide by 2 then by 4
    for (int k = 1; k <= 2; k++) begin
      wr(3'd0, 16'(1 + 2 * k), c);
      wr(3'd1, 16'h0001, c);
      p1 = -1; p2 = -1; hi = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (p1 >= 0 && p2 < 0 && pwm_out[0]) hi++;
        if (irq_period) begin
          if (p1 < 0) p1 = cyc;
          else if (p2 < 0) p2 = cyc;
        end
        if (p1 >= 0 && p2 < 0 && irq_period && pwm_out[0] && cyc != p1) hi++;
      end
      check($sformatf("R9 period div%0d", 1 << k), p2 - p1, 5 * (1 << k));
      check($sformatf("R9 width div%0d", 1 << k), hi, 2 * (1 << k));
    end

    repeat (4) @(negedge clk);
    check("R1 scoreboard drained", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule